// File: doc/BRIEF.md
# Ethernet Transmit Defer Controller

This block gates the start of every frame sent by a half-duplex Ethernet transmitter. A start request from the upper layer raises the busy flag and starts an inter-frame gap timer. The timer advances once per bit time, marked by a one-cycle bit-time enable. A full gap is 96 bit times. Carrier sense restarts the timer from zero if it appears during the first 60 bit times. During the last 36 bit times carrier is not looked at, and the timer runs to its end.

When the gap has run out, the block raises its transmit command and holds it while the frame goes out. A completion report from the transmitter, or a request to defer again, ends the command. The block then returns to timing a fresh gap. It drops busy and goes idle only when completion arrives with no new start request and no restart request.

Top module: `txgap_defer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in idle, with `busy` and `tx_go` low from the following cycle, even when reset lands in the middle of a gap. While idle with no start request, `tx_go` stays low.
- R2: A `start_req` seen at a clock edge while idle sets `busy` high from the next cycle, with `tx_go` still low, and starts a gap with the timer at zero.
- R3: If no carrier appears, `tx_go` goes high in the cycle after the 96th clock edge on which `bit_en` is high, counted from gap entry.
- R4: Only clock edges with `bit_en` high advance the gap. With `bit_en` high on every k-th edge after entry, `tx_go` rises after 96·k edges.
- R5: A `carrier` high at a bit-enabled edge that is the j-th such edge of the gap, with j from 1 to 60, restarts the timer. For a single such pulse, `tx_go` rises after bit edge j+96. A carrier held without a break keeps the timer at zero until it is released.
- R6: A `carrier` high at bit edges 61 to 96 of the gap has no effect: `tx_go` still rises after bit edge 96.
- R7: While `tx_go` is high it stays high, and `carrier` and `bit_en` have no effect, until `tx_done` or `redefer` is high at an edge.
- R8: A `redefer` at an edge while transmitting clears `tx_go` and keeps `busy` high. It then starts a fresh full 96-bit gap.
- R9: A `tx_done` while transmitting, with `redefer` and `start_req` low, makes the block idle with `busy` low. If `start_req` is high on that same edge, `busy` stays high and a fresh gap starts.
- R10: A `start_req` that arrives during a gap neither restarts nor shortens the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe marking each bit time |
| start_req | input | 1 | Start-transmit request from the upper layer |
| carrier | input | 1 | Carrier sense from the physical layer |
| tx_done | input | 1 | Transmitter reports the frame is finished |
| redefer | input | 1 | Request to abandon transmission and defer again |
| busy | output | 1 | High from acceptance of a request until idle |
| tx_go | output | 1 | Command to the transmitter to send the frame |

## Verification
The assertions assume the inputs are driven synchronously and are valid at every clock edge. They also assume that `tx_done` and `redefer` matter only while `tx_go` is high. The bench drives every input half a cycle away from the active edge. It raises `tx_done` and `redefer` only once it has seen `tx_go` high. It drives `bit_en` in regular patterns so that the number of bit edges to completion can be worked out in advance.

// File: rtl/txgap_defer.sv
module txgap_defer #(
  parameter int GAP_BITS  = 96,
  parameter int OPEN_BITS = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic start_req,
  input  logic carrier,
  input  logic tx_done,
  input  logic redefer,
  output logic busy,
  output logic tx_go
);

  localparam int CW = $clog2(GAP_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_BITS - 1);
  localparam logic [CW-1:0] OPEN = CW'(OPEN_BITS);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_SEND} st_t;

  st_t           state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (start_req) state <= S_GAP;
        end
        S_GAP: begin
          if (bit_en) begin
            if (carrier && cnt < OPEN) begin
              cnt <= '0;
            end else if (cnt == LAST) begin
              cnt   <= '0;
              state <= S_SEND;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_SEND: begin
          cnt <= '0;
          if (redefer || (tx_done && start_req)) state <= S_GAP;
          else if (tx_done)                      state <= S_IDLE;
        end
        default: begin
          state <= S_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign busy  = (state != S_IDLE);
  assign tx_go = (state == S_SEND);

endmodule

module txgap_defer_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic start_req,
  input logic tx_done,
  input logic redefer,
  input logic busy,
  input logic tx_go
);

  p_reset_r1: assert property (@(posedge clk) rst |=> (!busy && !tx_go));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy && !start_req |=> !tx_go);

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    !busy && start_req |=> busy && !tx_go);

  p_bit_edge_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_go && busy ##1 tx_go |-> $past(bit_en));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    tx_go && !tx_done && !redefer |=> tx_go);

  p_redefer_r8: assert property (@(posedge clk) disable iff (rst)
    tx_go && redefer |=> busy && !tx_go);

  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    tx_go && tx_done && !redefer && !start_req |=> !busy);

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    tx_go && tx_done && start_req |=> busy && !tx_go);

endmodule

bind txgap_defer txgap_defer_chk u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .start_req(start_req),
  .tx_done(tx_done), .redefer(redefer), .busy(busy), .tx_go(tx_go)
);

// File: tb/txgap_defer_test.sv
module txgap_defer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, start_req = 1'b0, carrier = 1'b0, tx_done = 1'b0, redefer = 1'b0;
  logic busy, tx_go;
  int total = 0, bad = 0;
  int n;

  always #5 clk = ~clk;

  txgap_defer uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .start_req(start_req),
    .carrier(carrier), .tx_done(tx_done), .redefer(redefer),
    .busy(busy), .tx_go(tx_go)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter();
    start_req = 1'b1;
    step();
    start_req = 1'b0;
    chk("R2 busy", busy, 1);
    chk("R2 tx_go", tx_go, 0);
  endtask

  // edge index e runs from 1; bit_en when e%k==0; carrier on edges cf..ct
  task automatic run(input int cf, input int ct, input int k, input int sr, output int edges);
    edges = -1;
    for (int e = 1; e <= 700; e++) begin
      bit_en    = (e % k == 0);
      carrier   = (e >= cf && e <= ct);
      start_req = (e == sr);
      step();
      if (tx_go) begin
        edges = e;
        break;
      end
    end
    bit_en = 1'b0; carrier = 1'b0; start_req = 1'b0;
  endtask

  task automatic go_idle();
    tx_done = 1'b1;
    step();
    tx_done = 1'b0;
    chk("R9 busy low after done", busy, 0);
    chk("R9 tx_go low after done", tx_go, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 1'b0;
    chk("R1 busy at reset", busy, 0);
    chk("R1 tx_go at reset", tx_go, 0);

    enter();
    run(0, 0, 1, 0, n);
    chk("R3 plain gap edges", n, 96);
    chk("R3 busy while sending", busy, 1);

    carrier = 1'b1; bit_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R7 tx_go held under carrier", tx_go, 1);
    end
    carrier = 1'b0; bit_en = 1'b0;
    go_idle();

    for (int k = 2; k <= 4; k++) begin
      enter();
      run(0, 0, k, 0, n);
      chk("R4 bit enable spacing", n, 96 * k);
      go_idle();
    end

    for (int j = 1; j <= 96; j++) begin
      enter();
      run(j, j, 1, 0, n);
      if (j <= 60) chk("R5 carrier restart", n, j + 96);
      else         chk("R6 late carrier ignored", n, 96);
      go_idle();
    end

    enter();
    run(1, 200, 1, 0, n);
    chk("R5 held carrier", n, 296);
    go_idle();

    enter();
    run(0, 0, 1, 50, n);
    chk("R10 start during gap", n, 96);

    redefer = 1'b1;
    step();
    redefer = 1'b0;
    chk("R8 busy after redefer", busy, 1);
    chk("R8 tx_go after redefer", tx_go, 0);
    run(0, 0, 1, 0, n);
    chk("R8 fresh gap", n, 96);

    tx_done = 1'b1; start_req = 1'b1;
    step();
    tx_done = 1'b0; start_req = 1'b0;
    chk("R9 busy kept with new start", busy, 1);
    chk("R9 tx_go cleared with new start", tx_go, 0);
    run(0, 0, 1, 0, n);
    chk("R9 fresh gap after restart", n, 96);
    go_idle();

    enter();
    bit_en = 1'b1;
    repeat (10) step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1 busy after mid-gap reset", busy, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 120; i++) begin
        step();
        if (tx_go || busy) seen++;
      end
      chk("R1 stays idle", seen, 0);
    end
    bit_en = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule